// File: doc/BRIEF.md
# Spacecraft CAN receive filter and frame queue

This block sits behind a CAN frame receiver that works in the CAN clock domain. For every completed standard-format frame it takes the destination node address from the low byte of the 11-bit identifier and checks it against a node address and compare mask that software programs. A frame that passes the check is written into an 8-entry queue that crosses into the processor clock domain. A frame that fails is thrown away. The processor is interrupted only while the queue holds frames, which means only frames addressed to this node, or broadcast, can raise the interrupt.

The processor uses a small register window. It has active-low chip select, output enable and write enable strobes, an 8-bit address and 16-bit data. The strobes are sampled with the processor clock. Reads are combinational while chip select and output enable are both low. A write takes effect once, on the first processor clock edge at which chip select and write enable are both low. Software reads the frame at the head of the queue, then writes a command to drop it. If a frame arrives while the queue is full, the frame is discarded and a sticky overrun flag is set.

Top module: `sc_rx_filter`

## Requirements
- R1: Let dest = frm_id[7:0]. A valid frame is accepted when ((dest XOR node) AND mask) == 0, where node and mask come from the config register (address 0x06: node in bits 7:0, mask in bits 15:8; it reads back as written). A mask bit of 1 means that bit is compared. The top three identifier bits (the sequence number) are not used by the filter.
- R2: A frame whose dest is 0xFF is accepted whatever the node and mask values are.
- R3: A frame that is not accepted is not stored and does not change irq or the status register.
- R4: Accepted frames come out in arrival order. Address 0x01 reads {dlc[3:0], 1'b0, id[10:0]} of the head frame. Addresses 0x02 to 0x05 read data word k = {byte 2k+1, byte 2k}, where byte n is frm_data[8n+7:8n] and byte 0 is the source address.
- R5: The status register (address 0x00) bit 0 and the irq output are 1 exactly when the queue holds at least one frame.
- R6: The queue holds 8 frames. An accepted frame that arrives while the queue is full is dropped, the first 8 frames are kept unchanged, and status bit 1 (overrun) is set.
- R7: A write to address 0x07 with bit 0 set removes the head frame; on an empty queue it has no effect. A write to 0x07 with bit 1 set clears the overrun flag.
- R8: rdata is 0 whenever cs_n or oe_n is high.
- R9: After reset the queue is empty, irq is 0, status reads 0x0000 and config reads 0xFF00 (node 0x00, full compare mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| can_clk | input | 1 | CAN-side clock |
| can_rst_n | input | 1 | CAN-side asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe: a received frame is on the frm_* inputs |
| frm_id | input | 11 | Standard identifier; bits 7:0 hold the destination, bits 10:8 the sequence number |
| frm_dlc | input | 4 | Payload length code, 0 to 8 |
| frm_data | input | 64 | Payload; byte n in bits 8n+7:8n |
| cpu_clk | input | 1 | Processor-side clock |
| cpu_rst_n | input | 1 | Processor-side asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, 0 when not reading |
| irq | output | 1 | High while accepted frames are waiting |

## Verification
The filter is exercised with four patterns. A destination that does not match the default node shows that rejected frames leave no trace. A broadcast destination under a full mask shows that 0xFF bypasses the compare. A partial mask whose frames differ only in uncompared bits and in the sequence field shows that only masked bits matter. A zero mask lets an arbitrary address through. Several stored frames with different identifiers, lengths and payload bytes are read back to show ordering and field placement. A burst of nine matching frames into an empty queue separates the drop-newest overflow rule from one that overwrites, and a pop on an empty queue followed by a fresh frame shows that the read pointer is not disturbed.

// File: rtl/sc_rx_pkg.sv
`timescale 1ns/1ps
package sc_rx_pkg;
  localparam int ID_W    = 11;
  localparam int DLC_W   = 4;
  localparam int NBYTES  = 8;
  localparam int DATA_W  = 8 * NBYTES;
  localparam int ADR_W   = 8;
  localparam int BUS_W   = 16;
  localparam int NODE_W  = 8;
  localparam int NWORDS  = DATA_W / BUS_W;

  localparam logic [NODE_W-1:0] BCAST_ADDR = '1;

  // register window
  localparam logic [ADR_W-1:0] REG_STAT  = 8'h00;
  localparam logic [ADR_W-1:0] REG_HEAD  = 8'h01;
  localparam logic [ADR_W-1:0] REG_DATA0 = 8'h02;
  localparam logic [ADR_W-1:0] REG_CFG   = 8'h06;
  localparam logic [ADR_W-1:0] REG_CMD   = 8'h07;

  typedef struct packed {
    logic [DLC_W-1:0]  dlc;
    logic [ID_W-1:0]   id;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/sc_rx_sync.sv
`timescale 1ns/1ps
module sc_rx_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sc_rx_accept.sv
`timescale 1ns/1ps
module sc_rx_accept
  import sc_rx_pkg::*;
(
  input  logic [NODE_W-1:0] dest,
  input  logic [NODE_W-1:0] node,
  input  logic [NODE_W-1:0] mask,
  output logic              hit
);
  always_comb begin
    hit = (dest == BCAST_ADDR) || (((dest ^ node) & mask) == '0);
  end
endmodule

// File: rtl/sc_rx_afifo.sv
`timescale 1ns/1ps
module sc_rx_afifo #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wfull,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          rempty
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wbin_nx, wgray, wgray_nx, rgray_w;
  logic [AW:0]   rbin, rbin_nx, rgray, rgray_nx, wgray_r;
  logic          wr_en, rd_en;

  // write side
  always_comb begin
    wfull    = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    wr_en    = wen && !wfull;
    wbin_nx  = wbin + {{AW{1'b0}}, wr_en};
    wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en) mem[wbin[AW-1:0]] <= wdata;
  end

  sc_rx_sync #(.W(AW+1)) u_rsync (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));

  // read side
  always_comb begin
    rempty   = (rgray == wgray_r);
    rd_en    = ren && !rempty;
    rbin_nx  = rbin + {{AW{1'b0}}, rd_en};
    rgray_nx = (rbin_nx >> 1) ^ rbin_nx;
    rdata    = mem[rbin[AW-1:0]];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
    end
  end

  sc_rx_sync #(.W(AW+1)) u_wsync (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));
endmodule

// File: rtl/sc_rx_filter.sv
`timescale 1ns/1ps
module sc_rx_filter
  import sc_rx_pkg::*;
#(
  parameter int FIFO_AW = 3
) (
  input  logic              can_clk,
  input  logic              can_rst_n,
  input  logic              frm_valid,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              cpu_clk,
  input  logic              cpu_rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADR_W-1:0]  addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  logic can_rn, cpu_rn;

  // reset asserted asynchronously, released on the local clock
  sc_rx_sync #(.W(1)) u_can_rst (.clk(can_clk), .rst_n(can_rst_n), .d(1'b1), .q(can_rn));
  sc_rx_sync #(.W(1)) u_cpu_rst (.clk(cpu_clk), .rst_n(cpu_rst_n), .d(1'b1), .q(cpu_rn));

  // ---------------- processor side ----------------
  logic              wr_act, wr_q, wr_pulse;
  logic              pop_pulse, clr_pulse, cfg_wr;
  logic [NODE_W-1:0] cfg_node, cfg_mask, cfg_node_nx, cfg_mask_nx;
  logic              cfg_tgl, cfg_tgl_nx;
  logic              ovf_tgl_c, ovf_tgl_d, ovf_set;
  logic              ovf_flag, ovf_flag_nx;
  logic              fifo_empty;
  rx_entry_t         head;

  always_comb begin
    wr_act    = !cs_n && !we_n;
    wr_pulse  = wr_act && !wr_q;
    cfg_wr    = wr_pulse && (addr == REG_CFG);
    pop_pulse = wr_pulse && (addr == REG_CMD) && wdata[0];
    clr_pulse = wr_pulse && (addr == REG_CMD) && wdata[1];
    ovf_set   = ovf_tgl_c ^ ovf_tgl_d;

    cfg_node_nx = cfg_wr ? wdata[NODE_W-1:0]        : cfg_node;
    cfg_mask_nx = cfg_wr ? wdata[2*NODE_W-1:NODE_W] : cfg_mask;
    cfg_tgl_nx  = cfg_tgl ^ cfg_wr;

    // a new overrun event wins over a clear in the same cycle
    if (ovf_set)        ovf_flag_nx = 1'b1;
    else if (clr_pulse) ovf_flag_nx = 1'b0;
    else                ovf_flag_nx = ovf_flag;
  end

  always_ff @(posedge cpu_clk or negedge cpu_rn) begin
    if (!cpu_rn) begin
      wr_q      <= 1'b0;
      cfg_node  <= '0;
      cfg_mask  <= '1;
      cfg_tgl   <= 1'b0;
      ovf_tgl_d <= 1'b0;
      ovf_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      wr_q      <= wr_act;
      cfg_node  <= cfg_node_nx;
      cfg_mask  <= cfg_mask_nx;
      cfg_tgl   <= cfg_tgl_nx;
      ovf_tgl_d <= ovf_tgl_c;
      ovf_flag  <= ovf_flag_nx;
      irq       <= !fifo_empty;
    end
  end

  always_comb begin
    rdata = '0;
    if (!cs_n && !oe_n) begin
      case (addr)
        REG_STAT:          rdata = {{(BUS_W-2){1'b0}}, ovf_flag, !fifo_empty};
        REG_HEAD:          rdata = {head.dlc, 1'b0, head.id};
        REG_DATA0:         rdata = head.data[0*BUS_W +: BUS_W];
        REG_DATA0 + 8'd1:  rdata = head.data[1*BUS_W +: BUS_W];
        REG_DATA0 + 8'd2:  rdata = head.data[2*BUS_W +: BUS_W];
        REG_DATA0 + 8'd3:  rdata = head.data[3*BUS_W +: BUS_W];
        REG_CFG:           rdata = {cfg_mask, cfg_node};
        default:           rdata = '0;
      endcase
    end
  end

  // ---------------- CAN side ----------------
  logic              cfg_tgl_s, cfg_tgl_sd, cfg_load;
  logic [NODE_W-1:0] cfg_node_c, cfg_mask_c;
  logic              hit, push, fifo_full, ovf_tgl, ovf_tgl_nx;
  rx_entry_t         entry;

  sc_rx_sync #(.W(1)) u_cfg_sync (.clk(can_clk), .rst_n(can_rn), .d(cfg_tgl), .q(cfg_tgl_s));
  sc_rx_sync #(.W(1)) u_ovf_sync (.clk(cpu_clk), .rst_n(cpu_rn), .d(ovf_tgl), .q(ovf_tgl_c));

  sc_rx_accept u_accept (
    .dest(frm_id[NODE_W-1:0]), .node(cfg_node_c), .mask(cfg_mask_c), .hit(hit)
  );

  always_comb begin
    cfg_load   = cfg_tgl_s ^ cfg_tgl_sd;
    push       = frm_valid && hit && !fifo_full;
    ovf_tgl_nx = ovf_tgl ^ (frm_valid && hit && fifo_full);
    entry.dlc  = frm_dlc;
    entry.id   = frm_id;
    entry.data = frm_data;
  end

  always_ff @(posedge can_clk or negedge can_rn) begin
    if (!can_rn) begin
      cfg_tgl_sd <= 1'b0;
      cfg_node_c <= '0;
      cfg_mask_c <= '1;
      ovf_tgl    <= 1'b0;
    end else begin
      cfg_tgl_sd <= cfg_tgl_s;
      if (cfg_load) begin
        cfg_node_c <= cfg_node;
        cfg_mask_c <= cfg_mask;
      end
      ovf_tgl <= ovf_tgl_nx;
    end
  end

  sc_rx_afifo #(.DW(ENTRY_W), .AW(FIFO_AW)) u_fifo (
    .wclk(can_clk), .wrst_n(can_rn), .wen(push), .wdata(entry), .wfull(fifo_full),
    .rclk(cpu_clk), .rrst_n(cpu_rn), .ren(pop_pulse), .rdata(head), .rempty(fifo_empty)
  );
endmodule

// File: rtl/sc_rx_filter_chk.sv
`timescale 1ns/1ps
module sc_rx_filter_chk (
  input logic        can_clk,
  input logic        can_rn,
  input logic        cpu_clk,
  input logic        cpu_rn,
  input logic        frm_valid,
  input logic [7:0]  dest,
  input logic [7:0]  cfg_node_c,
  input logic [7:0]  cfg_mask_c,
  input logic        hit,
  input logic        push,
  input logic        fifo_full,
  input logic        ovf_tgl,
  input logic        fifo_empty,
  input logic        irq,
  input logic        clr_pulse,
  input logic        ovf_set,
  input logic        ovf_flag,
  input logic        cs_n,
  input logic        oe_n,
  input logic [15:0] rdata
);
  // R1 and R2: only matching or broadcast frames reach the queue
  a_r1_push_matches: assert property (@(posedge can_clk) disable iff (!can_rn)
    push |-> (dest == 8'hFF || ((dest ^ cfg_node_c) & cfg_mask_c) == 8'h00));

  // R6: a full queue takes nothing in
  a_r6_no_push_full: assert property (@(posedge can_clk) disable iff (!can_rn)
    fifo_full |-> !push);

  // R6: an accepted frame meeting a full queue raises an overrun event
  a_r6_drop_signals: assert property (@(posedge can_clk) disable iff (!can_rn)
    (frm_valid && hit && fifo_full) |=> (ovf_tgl != $past(ovf_tgl)));

  // R5: interrupt follows the queue occupancy
  a_r5_irq_set: assert property (@(posedge cpu_clk) disable iff (!cpu_rn)
    !fifo_empty |=> irq);
  a_r5_irq_clr: assert property (@(posedge cpu_clk) disable iff (!cpu_rn)
    fifo_empty |=> !irq);

  // R7: a clear with no new overrun leaves the flag low
  a_r7_clear_works: assert property (@(posedge cpu_clk) disable iff (!cpu_rn)
    (clr_pulse && !ovf_set) |=> !ovf_flag);

  // R8: bus quiet when not reading
  a_r8_rdata_quiet: assert property (@(posedge cpu_clk) disable iff (!cpu_rn)
    (cs_n || oe_n) |-> (rdata == 16'h0000));
endmodule

bind sc_rx_filter sc_rx_filter_chk u_chk (
  .can_clk(can_clk), .can_rn(can_rn), .cpu_clk(cpu_clk), .cpu_rn(cpu_rn),
  .frm_valid(frm_valid), .dest(frm_id[7:0]), .cfg_node_c(cfg_node_c),
  .cfg_mask_c(cfg_mask_c), .hit(hit), .push(push), .fifo_full(fifo_full),
  .ovf_tgl(ovf_tgl), .fifo_empty(fifo_empty), .irq(irq), .clr_pulse(clr_pulse),
  .ovf_set(ovf_set), .ovf_flag(ovf_flag), .cs_n(cs_n), .oe_n(oe_n), .rdata(rdata)
);

// File: tb/sim_sc_rx_filter.sv
`timescale 1ns/1ps
module sim_sc_rx_filter;
  logic        can_clk = 1'b0, cpu_clk = 1'b0;
  logic        can_rst_n = 1'b0, cpu_rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [10:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 cpu_clk = ~cpu_clk;   // 50 MHz
  always #17 can_clk = ~can_clk;   // unrelated CAN clock

  sc_rx_filter u0 (
    .can_clk(can_clk), .can_rst_n(can_rst_n), .frm_valid(frm_valid),
    .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cs_n(cs_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fdata(input logic [7:0] s);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = s + 8'(k);
    return d;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge cpu_clk);
    addr = a; wdata = d; cs_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge cpu_clk);
    cs_n = 1'b1; we_n = 1'b1;
    @(negedge cpu_clk);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge cpu_clk);
    addr = a; cs_n = 1'b0; oe_n = 1'b0;
    @(negedge cpu_clk);
    d = rdata;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic send(input logic [10:0] id, input logic [3:0] dlc, input logic [63:0] d);
    @(negedge can_clk);
    frm_id = id; frm_dlc = dlc; frm_data = d; frm_valid = 1'b1;
    @(negedge can_clk);
    frm_valid = 1'b0;
    repeat (8) @(negedge cpu_clk);
  endtask

  task automatic set_cfg(input logic [7:0] node, input logic [7:0] mask);
    bus_write(8'h06, {mask, node});
    repeat (8) @(negedge can_clk);
  endtask

  task automatic expect_frame(input string req, input logic [10:0] id,
                              input logic [3:0] dlc, input logic [63:0] d);
    logic [15:0] v;
    bus_read(8'h01, v);
    check(req, v, {dlc, 1'b0, id});
    for (int k = 0; k < 4; k++) begin
      bus_read(8'(2 + k), v);
      check(req, v, d[16*k +: 16]);
    end
    bus_write(8'h07, 16'h0001);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R9 irq", {15'b0, irq}, 16'h0000);
    bus_read(8'h00, v); check("R9 status", v, 16'h0000);
    bus_read(8'h06, v); check("R9 config", v, 16'hFF00);
  endtask

  task automatic t_default_filter;
    logic [15:0] v;
    send(11'h312, 4'd8, fdata(8'hA0));            // dest 0x12, node 0x00: reject
    check("R3 irq after reject", {15'b0, irq}, 16'h0000);
    bus_read(8'h00, v); check("R3 status after reject", v, 16'h0000);
    send(11'h100, 4'd8, fdata(8'h10));            // dest 0x00: match
    check("R5 irq with data", {15'b0, irq}, 16'h0001);
    bus_read(8'h00, v); check("R5 status with data", v, 16'h0001);
    @(negedge cpu_clk); addr = 8'h01; cs_n = 1'b0; oe_n = 1'b1;
    @(negedge cpu_clk); check("R8 oe_n high", rdata, 16'h0000);
    cs_n = 1'b1; oe_n = 1'b0;
    @(negedge cpu_clk); check("R8 cs_n high", rdata, 16'h0000);
    oe_n = 1'b1;
    send(11'h6FF, 4'd2, fdata(8'h40));            // broadcast
    expect_frame("R4 first frame", 11'h100, 4'd8, fdata(8'h10));
    expect_frame("R2 broadcast frame", 11'h6FF, 4'd2, fdata(8'h40));
    repeat (3) @(negedge cpu_clk);
    check("R5 irq drained", {15'b0, irq}, 16'h0000);
    bus_read(8'h00, v); check("R5 status drained", v, 16'h0000);
  endtask

  task automatic t_mask_filter;
    logic [15:0] v;
    set_cfg(8'h34, 8'hF0);
    bus_read(8'h06, v); check("R1 config readback", v, 16'hF034);
    send(11'h044, 4'd1, fdata(8'h01));            // upper nibble differs: reject
    check("R1 masked reject", {15'b0, irq}, 16'h0000);
    send(11'h73A, 4'd3, fdata(8'h21));            // seq 7, low nibble ignored
    send(11'h03B, 4'd0, fdata(8'h31));
    check("R1 masked accept irq", {15'b0, irq}, 16'h0001);
    expect_frame("R1 masked accept seq", 11'h73A, 4'd3, fdata(8'h21));
    expect_frame("R1 masked accept", 11'h03B, 4'd0, fdata(8'h31));
    set_cfg(8'h34, 8'h00);
    send(11'h299, 4'd5, fdata(8'h77));
    expect_frame("R1 zero mask", 11'h299, 4'd5, fdata(8'h77));
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    set_cfg(8'h55, 8'hFF);
    for (int i = 0; i < 9; i++) send({3'(i), 8'h55}, 4'd8, fdata(8'(16 * i)));
    bus_read(8'h00, v); check("R6 full with overrun", v, 16'h0003);
    for (int i = 0; i < 8; i++) expect_frame("R6 kept frame", {3'(i), 8'h55}, 4'd8, fdata(8'(16 * i)));
    repeat (3) @(negedge cpu_clk);
    bus_read(8'h00, v); check("R6 ninth dropped, overrun sticky", v, 16'h0002);
    bus_write(8'h07, 16'h0002);
    bus_read(8'h00, v); check("R7 overrun cleared", v, 16'h0000);
    bus_write(8'h07, 16'h0001);                   // pop on empty
    bus_read(8'h00, v); check("R7 pop on empty", v, 16'h0000);
    check("R7 irq after empty pop", {15'b0, irq}, 16'h0000);
    send(11'h455, 4'd6, fdata(8'hC3));
    expect_frame("R7 pointer intact", 11'h455, 4'd6, fdata(8'hC3));
  endtask

  initial begin
    repeat (5) @(negedge cpu_clk);
    can_rst_n = 1'b1; cpu_rst_n = 1'b1;
    repeat (6) @(negedge cpu_clk);
    t_reset();
    t_default_filter();
    t_mask_filter();
    t_overflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge cpu_clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule